// File: doc/BRIEF.md
# Paired-Bit GPIO Set/Clear Register Bank

This block holds the output level and the output-driver direction of twelve general-purpose pins behind two 32-bit registers. The first word serves eight pins and the second serves four. Nothing is ever read, modified and written back. Each pin instead owns two write-one command pairs in its word. A level pair drives the pin low or high. A direction pair turns its output driver on or off. A write that carries a 1 in only one pin's pair bits changes that pin and leaves every other pin of the word as it was. Software can therefore issue plain full-word stores without a lock.

Each pin's readback depends on its direction. A driven pin shows its enable bit and shows its level in the clear position. An undriven pin shows its disable bit and shows, in the set position, the level sampled from the pad through a two-flop synchroniser. Software inverts an output by reading the clear position and then writing the opposite single command bit.

The register bus has a single cycle and no handshake. The bank accepts one access in every cycle, so there is no back-pressure. A write takes effect at the clock edge where the strobe is high. Read data follows the address combinationally. The pin outputs, output enables and pad inputs are plain level signals.

Top module: `gpx_pair_bank`

## Requirements
- R1: After reset every pin has its output enable low and its level latch low. Word 0 reads 0xAAAA0000 and word 1 reads 0x00AA0000 while the pad inputs are low.
- R2: For pin offset k in a word, writing 1 to bit 16+2k alone turns on that pin's driver (gpio_oe goes high). Writing 1 to bit 17+2k alone turns the driver off.
- R3: For pin offset k, writing 1 to bit 2k+1 alone sets the level latch to 1 (gpio_out high). Writing 1 to bit 2k alone sets the latch to 0. The latch is updated whether or not the driver is on.
- R4: A pair written as 00 or as 11 leaves that pin's level or direction unchanged. Pins whose pair bits are 0 are not affected by a write.
- R5: For a driven pin, the readback shows bit 16+2k = 1, bit 17+2k = 0, bit 2k = level latch and bit 2k+1 = 0.
- R6: For an undriven pin, the readback shows bit 16+2k = 0, bit 17+2k = 1, bit 2k = 0 and bit 2k+1 = the pad level. The pad level appears in the readback two clock edges after it is applied.
- R7: Word 1 (address 1) maps offsets 0..3 to pins 8..11. Its bits for offsets 4..7 (bits 15:8 and 31:24) ignore writes and read as 0.
- R8: Reading bit 2k of a driven pin and then writing only bit 2k (if it read 1) or only bit 2k+1 (if it read 0) inverts that pin's output.
- R9: A write changes state only in the addressed word, at the edge where reg_wr is high. reg_rdata reflects the new state right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Word select: 0 = pins 0..7, 1 = pins 8..11 |
| reg_wr | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write-one command bits |
| reg_rdata | output | 32 | Readback of the addressed word |
| gpio_in | input | 12 | Pad input levels, asynchronous |
| gpio_out | output | 12 | Output level latches |
| gpio_oe | output | 12 | Output driver enables |

## Verification
If a level or direction latch is wrong, it shows on gpio_out or gpio_oe in the very cycle after the faulty write. It also shows at once in the combinational readback of that word, so a lost or misdirected command is seen within one clock. A synchroniser stage that is missing or extra moves the input readback by one edge. The bench catches this by sampling an input step exactly one and two edges after it is applied. A decode fault that reaches a neighbouring pin or the other word appears as an unexpected change at a port that the write should not have touched.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned SLOTS  = HALF_W / 2;

  // Value taken by the state bit when only the lower bit of its pair is written.
  localparam logic LVL_LOW_BIT_VALUE = 1'b0;  // clear
  localparam logic DIR_LOW_BIT_VALUE = 1'b1;  // enable

  typedef enum logic [1:0] {
    PAIR_IDLE = 2'b00,
    PAIR_LOWB = 2'b01,
    PAIR_HIGB = 2'b10,
    PAIR_BOTH = 2'b11
  } pair_cmd_t;

  typedef struct packed {
    logic dis_rd;
    logic en_rd;
    logic set_rd;
    logic clr_rd;
  } pin_view_t;

  function automatic logic pair_next(input logic cur, input logic [1:0] cmd,
                                     input logic low_value);
    pair_cmd_t c;
    c = pair_cmd_t'(cmd);
    case (c)
      PAIR_LOWB: return low_value;
      PAIR_HIGB: return ~low_value;
      default:   return cur;
    endcase
  endfunction

  function automatic pin_view_t pin_view(input logic drv, input logic lvl,
                                         input logic smp);
    pin_view_t v;
    if (drv) begin
      v.dis_rd = 1'b0;
      v.en_rd  = 1'b1;
      v.set_rd = 1'b0;
      v.clr_rd = lvl;
    end else begin
      v.dis_rd = 1'b1;
      v.en_rd  = 1'b0;
      v.set_rd = smp;
      v.clr_rd = 1'b0;
    end
    return v;
  endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpx_pin_cell.sv
module gpx_pin_cell
  import gpx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [1:0] lvl_cmd,
  input  logic [1:0] dir_cmd,
  input  logic       pad_in,
  output logic       lvl_q,
  output logic       drv_q,
  output logic [1:0] lvl_rd,
  output logic [1:0] dir_rd
);
  logic      smp;
  pin_view_t view;

  gpx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (smp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      drv_q <= 1'b0;
    end else if (wr_hit) begin
      lvl_q <= pair_next(lvl_q, lvl_cmd, LVL_LOW_BIT_VALUE);
      drv_q <= pair_next(drv_q, dir_cmd, DIR_LOW_BIT_VALUE);
    end
  end

  always_comb begin
    view   = pin_view(drv_q, lvl_q, smp);
    lvl_rd = {view.set_rd, view.clr_rd};
    dir_rd = {view.dis_rd, view.en_rd};
  end

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && lvl_cmd == 2'b10) |=> lvl_q); // R3
  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && lvl_cmd == 2'b01) |=> !lvl_q); // R3
  AST_EN_MAKES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && dir_cmd == 2'b01) |=> drv_q); // R2
  AST_DIS_MAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && dir_cmd == 2'b10) |=> !drv_q); // R2
  AST_LVL_PAIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit || lvl_cmd[0] == lvl_cmd[1]) |=> $stable(lvl_q)); // R4
  AST_DIR_PAIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit || dir_cmd[0] == dir_cmd[1]) |=> $stable(drv_q)); // R4
endmodule

// File: rtl/gpx_word.sv
module gpx_word
  import gpx_pkg::*;
#(
  parameter int unsigned PINS        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   lvl_q,
  output logic [PINS-1:0]   drv_q,
  output logic [WORD_W-1:0] rd_word
);
  logic [SLOTS-1:0][1:0] lvl_rd_s;
  logic [SLOTS-1:0][1:0] dir_rd_s;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (k < PINS) begin : g_pin
      gpx_pin_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .lvl_cmd(wdata[2*k +: 2]),
        .dir_cmd(wdata[HALF_W + 2*k +: 2]),
        .pad_in (pad_in[k]),
        .lvl_q  (lvl_q[k]),
        .drv_q  (drv_q[k]),
        .lvl_rd (lvl_rd_s[k]),
        .dir_rd (dir_rd_s[k])
      );
    end else begin : g_empty
      logic [3:0] unused_cmd_bits;
      assign unused_cmd_bits = {wdata[HALF_W + 2*k +: 2], wdata[2*k +: 2]};
      assign lvl_rd_s[k] = 2'b00;
      assign dir_rd_s[k] = 2'b00;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < SLOTS; k++) begin
      rd_word[2*k +: 2]          = lvl_rd_s[k];
      rd_word[HALF_W + 2*k +: 2] = dir_rd_s[k];
    end
  end
endmodule

// File: rtl/gpx_pair_bank.sv
module gpx_pair_bank
  import gpx_pkg::*;
#(
  parameter int unsigned PINS_A      = 8,
  parameter int unsigned PINS_B      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_WORDS  = 2,
  localparam int unsigned ADDR_W     = $clog2(NUM_WORDS),
  localparam int unsigned NPINS      = PINS_A + PINS_B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [NPINS-1:0]  gpio_in,
  output logic [NPINS-1:0]  gpio_out,
  output logic [NPINS-1:0]  gpio_oe
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] rd_words;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int unsigned WP   = (w == 0) ? PINS_A : PINS_B;
    localparam int unsigned BASE = (w == 0) ? 0 : PINS_A;
    logic hit;
    assign hit = reg_wr && (reg_addr == ADDR_W'(w));

    gpx_word #(.PINS(WP), .SYNC_STAGES(SYNC_STAGES)) u_word (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (hit),
      .wdata  (reg_wdata),
      .pad_in (gpio_in[BASE +: WP]),
      .lvl_q  (gpio_out[BASE +: WP]),
      .drv_q  (gpio_oe[BASE +: WP]),
      .rd_word(rd_words[w])
    );
  end

  assign reg_rdata = rd_words[reg_addr];

  for (genvar k = 0; k < PINS_A; k++) begin : g_oe_chk
    AST_OE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(0)) |-> (reg_rdata[HALF_W + 2*k] == gpio_oe[k])); // R5
    AST_LVL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(0) && gpio_oe[k]) |-> (reg_rdata[2*k] == gpio_out[k])); // R5
  end

  if (PINS_B < SLOTS) begin : g_gap_chk
    AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(1)) |->
        (reg_rdata[WORD_W-1:HALF_W+2*PINS_B] == '0 &&
         reg_rdata[HALF_W-1:2*PINS_B] == '0)); // R7
  end
endmodule

// File: tb/gpx_pair_bank_bench.sv
`timescale 1ns/1ps
module gpx_pair_bank_bench;
  localparam int NP = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [0:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP-1:0] gpio_in = '0;
  logic [NP-1:0] gpio_out, gpio_oe;

  int n_chk = 0;
  int n_bad = 0;

  logic [NP-1:0] m_lvl = '0, m_dir = '0, m_q1 = '0, m_q2 = '0;
  logic [NP-1:0] cur_in = '0;

  always #2 clk = ~clk;

  gpx_pair_bank u_gpx_pair_bank (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic a);
    logic [31:0] r = '0;
    for (int k = 0; k < 8; k++) begin
      int g = a ? 8 + k : k;
      if (a && k >= 4) continue;
      if (m_dir[g]) begin
        r[16 + 2*k] = 1'b1;
        r[2*k]      = m_lvl[g];
      end else begin
        r[17 + 2*k] = 1'b1;
        r[2*k + 1]  = m_q2[g];
      end
    end
    return r;
  endfunction

  function automatic logic nxt(input logic cur, input logic [1:0] p, input logic lowv);
    if (p == 2'b01) return lowv;
    if (p == 2'b10) return ~lowv;
    return cur;
  endfunction

  // one bus cycle; called at a negative edge, returns at the next negative edge
  task automatic cycle(input logic a, input logic wr, input logic [31:0] wd, input string req);
    reg_addr  = a;
    reg_wr    = wr;
    reg_wdata = wd;
    gpio_in   = cur_in;
    @(posedge clk);
    m_q2 = m_q1;
    m_q1 = cur_in;
    if (wr) begin
      for (int k = 0; k < 8; k++) begin
        int g = a ? 8 + k : k;
        if (a && k >= 4) continue;
        m_lvl[g] = nxt(m_lvl[g], wd[2*k +: 2], 1'b0);
        m_dir[g] = nxt(m_dir[g], wd[16 + 2*k +: 2], 1'b1);
      end
    end
    @(negedge clk);
    reg_wr = 1'b0;
    check(req, "gpio_out", 32'(gpio_out), 32'(m_lvl));
    check(req, "gpio_oe", 32'(gpio_oe), 32'(m_dir));
    check(req, "reg_rdata", reg_rdata, exp_word(a));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int seed;
    logic [31:0] tg;
    seed = $urandom(32'd4711);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", "gpio_out", 32'(gpio_out), 32'h0);
    check("R1", "gpio_oe", 32'(gpio_oe), 32'h0);
    reg_addr = 1'b0; #0.5;
    check("R1", "word0", reg_rdata, 32'hAAAA_0000);
    reg_addr = 1'b1; #0.5;
    check("R1", "word1", reg_rdata, 32'h00AA_0000);

    // R2 enable pin 3, R3 set pin 3
    cycle(1'b0, 1'b1, 32'h0040_0000, "R2");
    check("R2", "oe3", 32'(gpio_oe[3]), 32'd1);
    cycle(1'b0, 1'b1, 32'h0000_0080, "R3");
    check("R3", "out3", 32'(gpio_out[3]), 32'd1);
    check("R5", "rd clr3", 32'(reg_rdata[6]), 32'd1);

    // R8 toggle twice
    for (int t = 0; t < 2; t++) begin
      cycle(1'b0, 1'b0, 32'h0, "R8");
      tg = reg_rdata[6] ? 32'h0000_0040 : 32'h0000_0080;
      cycle(1'b0, 1'b1, tg, "R8");
      check("R8", "out3 toggled", 32'(gpio_out[3]), (t == 0) ? 32'd0 : 32'd1);
    end

    // R4 both-ones pairs hold
    cycle(1'b0, 1'b1, 32'h00C0_00C0, "R4");
    check("R4", "out3 held", 32'(gpio_out[3]), 32'd1);
    check("R4", "oe3 held", 32'(gpio_oe[3]), 32'd1);

    // R7 word1 offset 3 -> pin 11; unused offsets ignored
    cycle(1'b1, 1'b1, 32'h0040_0080, "R7");
    check("R7", "pin11 oe", 32'(gpio_oe[11]), 32'd1);
    check("R7", "pin11 out", 32'(gpio_out[11]), 32'd1);
    cycle(1'b1, 1'b1, 32'hFF00_FF00, "R7");
    check("R7", "gap bits", reg_rdata & 32'hFF00_FF00, 32'h0);
    check("R7", "pins unchanged", 32'(gpio_oe[11:8]), 32'h8);

    // R9 word0 write does not touch word1 pins
    cycle(1'b0, 1'b1, 32'h0001_0002, "R9");
    check("R9", "word1 out", 32'(gpio_out[11:8]), 32'h8);

    // R6 input latency on pin 5
    cur_in[5] = 1'b1;
    cycle(1'b0, 1'b0, 32'h0, "R6");
    check("R6", "after 1 edge", 32'(reg_rdata[11]), 32'd0);
    cycle(1'b0, 1'b0, 32'h0, "R6");
    check("R6", "after 2 edges", 32'(reg_rdata[11]), 32'd1);

    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic a;
      logic w;
      logic [31:0] d;
      a = 1'($urandom % 2);
      w = ($urandom % 4) != 0;
      d = ($urandom % 2) ? $urandom : (32'd1 << ($urandom % 32));
      if ($urandom % 3 == 0) cur_in = NP'($urandom);
      cycle(a, w, d, "R9");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule